// File: doc/BRIEF.md
# Word-Oriented SPI Master

This block moves whole words between a host and a serial device over a four-wire SPI link in mode 0. The host supplies a 32-bit word and a 2-bit size code and pulses a write strobe. The block then sends the top 8, 16, 24 or 32 bits of that word, most significant bit first. While it sends, it collects the same number of bits from the device. When the word ends it presents the received bits and pulses a valid flag for one clock.

Several words can form one device transaction. If the host raises the next strobe during the final bit of a word, the next word follows with no idle clock. If the hold input is high when a word ends and nothing is queued, chip select stays low and the link stays open for a later word. If hold is low, chip select goes high. Busy stays high through a short gap, so that the device sees a minimum deselect time.

SCK runs at half the system clock. Each bit takes two clock cycles: SCK is low in the first and high in the second. MOSI changes only as SCK falls. MISO is sampled at the end of the high half of SCK.

Top module: `spi_word_master`

## Requirements
- R1: While reset is asserted and directly after it, chip select is high, SCK is low, busy is low and valid is low.
- R2: The size code sets the bit count of a word: 00 gives 8 SCK pulses, 01 gives 16, 10 gives 24 and 11 gives 32. Each bit lasts two clock cycles, with SCK low in the first and high in the second.
- R3: MOSI sends bit 31 of the input word first and then lower bits in order. Bits below the selected size are never sent. MOSI does not change in the cycle where SCK rises. SCK is low whenever chip select is high.
- R4: In the cycle after the final bit, valid is high for exactly one cycle. In that cycle the output word holds the received bits, with the last bit received in bit 0. Bits above the selected size read zero.
- R5: A strobe seen while busy is low and chip select is high starts a word. Busy and chip select are both active in the next cycle.
- R6: A strobe during the final bit of a word, in either half of that bit, starts the next word right after the current one. Chip select stays low and no cycle is lost.
- R7: If hold is high when a word ends and no strobe is queued, chip select stays low while busy and SCK stay low. A later strobe continues the same transaction. Dropping hold with no strobe raises chip select in the next cycle.
- R8: If hold is low when a word ends and no strobe is queued, chip select goes high in the cycle after the final bit. Busy stays high for two more cycles. Chip select then stays high for at least two cycles.
- R9: A strobe while busy is high, outside the final bit of a word, is ignored. No further bits are sent and no extra valid pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe: start or queue a word |
| hold_i | input | 1 | Keep chip select low after a word ends |
| word_i | input | 32 | Word to send, aligned to the top |
| len_i | input | 2 | Size code (bytes minus one) |
| word_o | output | 32 | Received bits, right-aligned |
| valid_o | output | 1 | One-cycle pulse when a word completes |
| busy_o | output | 1 | Word shifting or deselect gap in progress |
| sck_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Device select, active low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
Some rules hold on every cycle, and the assertions check those: SCK stays low while the device is deselected, SCK pulses only while busy, MOSI is stable as SCK rises, valid lasts a single cycle, a strobe from idle is taken at once, the deselect gap is held, and an open link stays quiet. Other behaviour can only be shown by the bench scenarios with a serial device model. These are the exact bit counts for each size code, the bit order on both data lines, zero fill of the output word, chaining with no gap for strobes in either half of the last bit, and strobes ignored in the middle of a word.

// File: rtl/spi_word_pkg.sv
`timescale 1ns/1ps
package spi_word_pkg;

    // Sequencer states of the word engine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // deselected, ready for a strobe
        ST_SHIFT = 2'd1,   // bits moving on the link
        ST_OPEN  = 2'd2,   // selected, link parked between words
        ST_GAP   = 2'd3    // deselected, minimum high time running
    } spi_word_st_e;

endpackage

// File: rtl/spi_word_lencode.sv
`timescale 1ns/1ps
// Turns a byte-count code into the index of the last bit of a word.
module spi_word_lencode #(
    parameter int LEN_W  = 2,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] last_idx_o
);
    localparam int EXT_W = CNT_W + LEN_W + 1;

    logic [EXT_W-1:0] bytes_w;
    logic [EXT_W-1:0] bits_w;

    always_comb begin
        bytes_w    = EXT_W'(len_i) + EXT_W'(1);
        bits_w     = bytes_w * EXT_W'(BYTE_W);
        last_idx_o = CNT_W'(bits_w - EXT_W'(1));
    end
endmodule

// File: rtl/spi_word_shift.sv
`timescale 1ns/1ps
// Transmit and receive shift registers for one word.
module spi_word_shift #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic              shift_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [WORD_W-1:0] rx_next_o
);
    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    assign rx_next_o = {sh_q.rx[WORD_W-2:0], miso_i};
    assign mosi_o    = sh_q.tx[WORD_W-1];

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            // a fresh word starts with an empty receive register
            sh_d.tx = load_word_i;
            sh_d.rx = '0;
        end else if (shift_i) begin
            sh_d.tx = {sh_q.tx[WORD_W-2:0], 1'b0};
            sh_d.rx = rx_next_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/spi_word_master.sv
`timescale 1ns/1ps
module spi_word_master
    import spi_word_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int BYTE_W  = 8,
    parameter int LEN_W   = 2,
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              hold_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              busy_o,
    output logic              sck_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(GAP_CYC - 1);

    typedef struct packed {
        spi_word_st_e      st;
        logic              phase;      // 0: SCK low half, 1: SCK high half
        logic [CNT_W-1:0]  bitcnt;     // bits left after the current one
        logic [GAP_W-1:0]  gapcnt;
        logic              pend;       // queued word waiting for word end
        logic [WORD_W-1:0] pend_word;
        logic [LEN_W-1:0]  pend_len;
        logic              cs_n;
        logic              sck;
        logic              valid;
        logic [WORD_W-1:0] dout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              start_w;
    logic [WORD_W-1:0] start_word_w;
    logic [LEN_W-1:0]  start_len_w;
    logic              shift_w;
    logic [CNT_W-1:0]  last_idx_w;
    logic [WORD_W-1:0] rx_next_w;
    logic              last_bit_w;

    spi_word_lencode #(
        .LEN_W  (LEN_W),
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) u_len (
        .len_i      (start_len_w),
        .last_idx_o (last_idx_w)
    );

    spi_word_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start_w),
        .load_word_i (start_word_w),
        .shift_i     (shift_w),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .rx_next_o   (rx_next_w)
    );

    assign last_bit_w = (ctl_q.bitcnt == '0);

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.valid  = 1'b0;
        start_w      = 1'b0;
        start_word_w = word_i;
        start_len_w  = len_i;
        shift_w      = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wr_i) start_w = 1'b1;
            end
            ST_OPEN: begin
                if (wr_i) begin
                    start_w = 1'b1;
                end else if (!hold_i) begin
                    ctl_d.st     = ST_GAP;
                    ctl_d.cs_n   = 1'b1;
                    ctl_d.gapcnt = GAP_INIT;
                end
            end
            ST_SHIFT: begin
                if (!ctl_q.phase) begin
                    ctl_d.sck   = 1'b1;
                    ctl_d.phase = 1'b1;
                    // early strobe in the low half of the final bit is queued
                    if (last_bit_w && wr_i && !ctl_q.pend) begin
                        ctl_d.pend      = 1'b1;
                        ctl_d.pend_word = word_i;
                        ctl_d.pend_len  = len_i;
                    end
                end else begin
                    ctl_d.sck   = 1'b0;
                    ctl_d.phase = 1'b0;
                    shift_w     = 1'b1;
                    if (!last_bit_w) begin
                        ctl_d.bitcnt = ctl_q.bitcnt - CNT_W'(1);
                    end else begin
                        ctl_d.valid = 1'b1;
                        ctl_d.dout  = rx_next_w;
                        if (ctl_q.pend) begin
                            start_w      = 1'b1;
                            start_word_w = ctl_q.pend_word;
                            start_len_w  = ctl_q.pend_len;
                            ctl_d.pend   = 1'b0;
                        end else if (wr_i) begin
                            start_w = 1'b1;
                        end else if (hold_i) begin
                            ctl_d.st = ST_OPEN;
                        end else begin
                            ctl_d.st     = ST_GAP;
                            ctl_d.cs_n   = 1'b1;
                            ctl_d.gapcnt = GAP_INIT;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (ctl_q.gapcnt == '0) ctl_d.st = ST_IDLE;
                else                    ctl_d.gapcnt = ctl_q.gapcnt - GAP_W'(1);
            end
            default: ;
        endcase

        if (start_w) begin
            ctl_d.st     = ST_SHIFT;
            ctl_d.phase  = 1'b0;
            ctl_d.sck    = 1'b0;
            ctl_d.cs_n   = 1'b0;
            ctl_d.bitcnt = last_idx_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_IDLE;
            ctl_q.phase     <= 1'b0;
            ctl_q.bitcnt    <= '0;
            ctl_q.gapcnt    <= '0;
            ctl_q.pend      <= 1'b0;
            ctl_q.pend_word <= '0;
            ctl_q.pend_len  <= '0;
            ctl_q.cs_n      <= 1'b1;
            ctl_q.sck       <= 1'b0;
            ctl_q.valid     <= 1'b0;
            ctl_q.dout      <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign word_o  = ctl_q.dout;
    assign valid_o = ctl_q.valid;
    assign sck_o   = ctl_q.sck;
    assign cs_n_o  = ctl_q.cs_n;
    assign busy_o  = (ctl_q.st == ST_SHIFT) || (ctl_q.st == ST_GAP);

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o) else $error("SCK active while deselected"); // R3
    AST_MOSI_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $stable(mosi_o)) else $error("MOSI moved on SCK rise"); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o) else $error("valid wider than one cycle"); // R4
    AST_STROBE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cs_n_o && wr_i) |=> (busy_o && !cs_n_o)) else $error("strobe from idle lost"); // R5
    AST_OPEN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !cs_n_o && !wr_i && hold_i) |=> (!busy_o && !cs_n_o)) else $error("open link left"); // R7
    AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> cs_n_o ##1 cs_n_o) else $error("deselect gap too short"); // R8
    AST_SCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> (busy_o && !cs_n_o)) else $error("SCK outside a word"); // R2
endmodule

// File: tb/spi_word_master_test.sv
`timescale 1ns/1ps
module spi_word_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        hold = 1'b0;
    logic [31:0] win = '0;
    logic [1:0]  lin = '0;
    wire  [31:0] wout;
    wire         valid, busy, sck, cs_n, mosi, miso;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_word_master uut (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .hold_i(hold), .word_i(win),
        .len_i(lin), .word_o(wout), .valid_o(valid), .busy_o(busy),
        .sck_o(sck), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
    );

    // serial device model, mode 0: capture on SCK rise, advance on SCK fall
    logic [63:0] s_stream = '0;
    logic [63:0] s_cap = '0;
    int          s_cnt = 0;
    int          s_pos = 0;
    logic        s_clr = 1'b0;

    always @(s_clr or sck) begin
        if (s_clr) begin
            s_cap = '0; s_cnt = 0; s_pos = 0;
        end else if (sck === 1'b1) begin
            s_cap = {s_cap[62:0], mosi};
            s_cnt = s_cnt + 1;
        end else begin
            s_pos = s_cnt;
        end
    end
    assign miso = (s_pos < 64) ? s_stream[6'(63 - s_pos)] : 1'b0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic int nbits(logic [1:0] l);
        return 8 * (int'(l) + 1);
    endfunction

    function automatic logic [31:0] tx_exp(logic [31:0] w, int n);
        return w >> (32 - n);
    endfunction

    function automatic logic [31:0] rx_exp(logic [63:0] st, int off, int n);
        logic [63:0] t;
        t = st << off;
        return 32'(t >> (64 - n));
    endfunction

    function automatic logic [63:0] low_mask(int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    task automatic slv_prep(logic [63:0] st);
        s_stream = st;
        s_clr = 1'b1;
        #1;
        s_clr = 1'b0;
    endtask

    // drive one strobe from a falling edge; returns at index 0 of the word
    task automatic strobe(logic [31:0] w, logic [1:0] l, logic h);
        wr = 1'b1; win = w; lin = l; hold = h;
        tick(1);
        wr = 1'b0; win = $urandom;
    endtask

    task automatic single(logic [31:0] w, logic [1:0] l, logic [63:0] st);
        int n;
        n = nbits(l);
        slv_prep(st);
        strobe(w, l, 1'b0);
        chk("R5 busy and select after strobe", {busy, cs_n}, 2'b10);
        tick(2 * n - 1);
        chk("R4 no valid before last bit", valid, 0);
        tick(1);
        chk("R4 valid at word end", valid, 1);
        chk("R4 received word", wout, rx_exp(st, 0, n));
        chk("R8 select released, still busy", {cs_n, busy}, 2'b11);
        tick(1);
        chk("R4 valid single cycle", valid, 0);
        chk("R8 busy during gap", {busy, cs_n}, 2'b11);
        tick(1);
        chk("R8 idle after gap", busy, 0);
        chk("R2 SCK pulse count", s_cnt, n);
        chk("R3 MOSI bits", s_cap & low_mask(n), 64'(tx_exp(w, n)));
    endtask

    task automatic chained(logic [31:0] w1, logic [1:0] l1, logic [31:0] w2,
                           logic [1:0] l2, logic [63:0] st, logic early);
        int n1, n2;
        n1 = nbits(l1); n2 = nbits(l2);
        slv_prep(st);
        strobe(w1, l1, 1'b0);
        if (early) begin
            tick(2 * n1 - 2);
            wr = 1'b1; win = w2; lin = l2;
            tick(1);
            wr = 1'b0;
            tick(1);
        end else begin
            tick(2 * n1 - 1);
            wr = 1'b1; win = w2; lin = l2;
            tick(1);
            wr = 1'b0;
        end
        chk("R6 first word valid", valid, 1);
        chk("R6 first word data", wout, rx_exp(st, 0, n1));
        chk("R6 select held between words", {cs_n, busy}, 2'b01);
        tick(2 * n2);
        chk("R6 second word valid without gap", valid, 1);
        chk("R6 second word data", wout, rx_exp(st, n1, n2));
        chk("R8 release after chain", cs_n, 1);
        tick(2);
        chk("R6 total bits", s_cnt, n1 + n2);
        chk("R6 MOSI stream", s_cap & low_mask(n1 + n2),
            (64'(tx_exp(w1, n1)) << n2) | 64'(tx_exp(w2, n2)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] st;
        int n1, n2;
        void'($urandom(32'h5A17));

        tick(2);
        chk("R1 state in reset", {cs_n, sck, busy, valid}, 4'b1000);
        rst_n = 1'b1;
        tick(2);
        chk("R1 state after reset", {cs_n, sck, busy, valid}, 4'b1000);

        // every size code, directed patterns
        single(32'hA5C3_0F81, 2'b00, 64'hF0E1_D2C3_B4A5_9687);
        single(32'h8001_7FFE, 2'b01, 64'h1234_5678_9ABC_DEF0);
        single(32'h3C5A_9601, 2'b10, 64'hFFFF_0000_AAAA_5555);
        single(32'hDEAD_BEEF, 2'b11, 64'h0F1E_2D3C_4B5A_6978);

        // chaining, strobe in each half of the final bit
        chained(32'h9F00_0000, 2'b00, 32'h1122_3344, 2'b11, 64'hC3A5_5A3C_9669_0FF0, 1'b1);
        chained(32'h0BAB_CDEF, 2'b11, 32'h7E00_0000, 2'b00, 64'h8421_8421_1248_1248, 1'b0);

        // hold keeps the link open, later word continues it
        st = 64'hB7E1_5162_8AED_2A6A;
        slv_prep(st);
        n1 = 16; n2 = 24;
        strobe(32'h05AA_0000, 2'b01, 1'b1);
        tick(2 * n1);
        chk("R7 word end under hold", {valid, cs_n}, 2'b10);
        chk("R7 data under hold", wout, rx_exp(st, 0, n1));
        tick(1);
        chk("R7 parked open", {busy, cs_n, sck}, 3'b000);
        tick(5);
        chk("R7 still parked", {busy, cs_n, sck}, 3'b000);
        strobe(32'h6699_C300, 2'b10, 1'b0);
        chk("R7 continue busy", {busy, cs_n}, 2'b10);
        tick(2 * n2);
        chk("R7 continued word data", wout, rx_exp(st, n1, n2));
        chk("R8 release after continued word", {valid, cs_n}, 2'b11);
        tick(2);
        chk("R7 MOSI across open link", s_cap & low_mask(n1 + n2),
            (64'(16'h05AA) << n2) | 64'(24'h6699C3));

        // hold dropped while parked
        slv_prep(64'h0);
        strobe(32'h4200_0000, 2'b00, 1'b1);
        tick(16);
        tick(2);
        chk("R7 parked before drop", {busy, cs_n}, 2'b00);
        hold = 1'b0;
        tick(1);
        chk("R7 drop releases select", {cs_n, busy}, 2'b11);
        tick(2);
        chk("R8 idle after drop", busy, 0);

        // strobe in mid word is ignored
        st = 64'h5555_AAAA_3333_CCCC;
        slv_prep(st);
        strobe(32'hE700_0000, 2'b00, 1'b0);
        tick(2);
        wr = 1'b1; win = 32'hFFFF_FFFF; lin = 2'b11;
        tick(1);
        wr = 1'b0;
        tick(13);
        chk("R9 word ends on time", {valid, cs_n}, 2'b11);
        chk("R9 data unaffected", wout, rx_exp(st, 0, 8));
        tick(6);
        chk("R9 no second word", {busy, cs_n, valid}, 3'b010);
        chk("R9 bit count", s_cnt, 8);

        // constrained random single words
        for (int i = 0; i < 30; i++) begin
            single($urandom, 2'($urandom), {$urandom, $urandom});
        end
        // constrained random chained pairs
        for (int i = 0; i < 10; i++) begin
            chained($urandom, 2'($urandom), $urandom, 2'($urandom),
                    {$urandom, $urandom}, 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule